// File: doc/BRIEF.md
# Asynchronous Memory Strobe and Wait Controller

This block connects an internal request port to an external asynchronous memory bus. Each accepted request is matched against up to four chip-select windows. A window is enabled by a bit and placed by a 4-bit slot number, so it covers one 16 MB slot inside the 256 MB region whose top address nibble is 0x1. A request that falls inside an enabled window drives one active-low chip select, a read or a write strobe, the low 24 address bits and, for writes, the write data with its output enable. All of these timings run on a strobe period that is a runtime-selected multiple of the system clock.

Each chip select has its own settings. A data-wait count lengthens the strobe. An idle count and a write-recovery count hold the request port closed after the access has completed. An enable bit and a pin selector tie the chip select to one of the active-low external wait inputs, which can stretch the strobe further.

The request port follows valid/ready rules. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The response port is also valid/ready. `rsp_valid` and its data stay asserted and unchanged until `rsp_ready` is seen high, and no new request is taken before that.

Top module: `emi_wait_ctrl`

## Requirements
- R1: An address whose bits [31:28] equal 0x1 and whose bits [27:24] equal the slot of an enabled chip select drives that chip select's `mem_cs_n` bit low, and only that bit, for the whole strobe. `mem_addr` carries address bits [23:0] during the strobe.
- R2: When several enabled chip selects claim the same slot, the one with the lowest index is used, and its timing settings apply.
- R3: A request outside every enabled window produces a response with `rsp_err`=1. It asserts no chip select and no strobe, and it adds no gap after the response.
- R4: The strobe period D is `clk_div_sel` clamped to the range 2..6. Values 0 and 1 act as 2, and value 7 acts as 6. All wait counts are whole multiples of D.
- R5: With no external wait, the strobe is low for exactly (1 + data_wait) × D system cycles. A read uses `mem_rd_n` alone. A write uses `mem_wr_n` with `mem_wdata_oe`=1 and `mem_wdata` equal to the request data.
- R6: After the response handshake, `req_ready` stays low for idle × D cycles after a read, and for (idle + write_recovery) × D cycles after a write. A zero total adds no cycle.
- R7: When wait use is enabled, the selected wait input passes through a two-flop synchronizer. It is looked at only at period ends after the data-wait periods have passed. If the pin is released during strobe cycle n, the strobe lasts D × max(1 + data_wait, ceil((n + 2) / D)) cycles.
- R8: A low wait input has no effect when wait use is disabled for the chip select, or when the pin selector names a different pin.
- R9: `req_ready` is high only when no access, response or gap is in progress. While it is high, no chip select and no strobe is active.
- R10: A read response returns `mem_rdata` as sampled at the clock edge that ends the strobe. While `rsp_ready` is low, `rsp_valid`, `rsp_rdata` and `rsp_err` hold.
- R11: After reset, all chip selects and both strobes are high, `req_ready` is 1 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div_sel | input | 3 | Strobe period in system cycles (clamped 2..6) |
| cs_enable | input | NUM_CS | Window enable per chip select |
| cs_slot | input | NUM_CS*4 | 16 MB slot number per chip select |
| cs_data_wait | input | NUM_CS*CNT_W | Extra strobe periods per chip select |
| cs_wrec_wait | input | NUM_CS*CNT_W | Write-recovery periods per chip select |
| cs_idle_wait | input | NUM_CS*CNT_W | Idle periods per chip select |
| cs_pin_use | input | NUM_CS | Enables external wait for the chip select |
| cs_pin_sel | input | NUM_CS*PIN_W | External wait pin chosen by the chip select |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with valid |
| rsp_rdata | output | DATA_W | Read data |
| rsp_err | output | 1 | No window matched |
| mem_cs_n | output | NUM_CS | Active-low chip selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_addr | output | 24 | Address within the 16 MB window |
| mem_wdata | output | DATA_W | Write data to memory |
| mem_wdata_oe | output | 1 | Write data drive enable |
| mem_rdata | input | DATA_W | Read data from memory |
| ext_wait_n | input | NUM_WAIT | Active-low external wait inputs |

## Verification
The bench sweeps every legal period against a range of data-wait, idle and recovery counts for both reads and writes. A design off by one register stage, or one that counts waits in system cycles rather than periods, shows up there as a strobe length or a gap length that is wrong. Wait pins are released in each strobe cycle, one after another, so a design that samples the pin without the synchronizer, or samples it before the data-wait has elapsed, ends the strobe one period early or late. Overlapping windows, unmapped slots, disabled windows and addresses outside the region catch a design that lets a higher index win or that still pulses a strobe on an error. Divider settings outside the legal range, and a response held back by a low `rsp_ready`, expose a missing clamp and a response that is not held.

// File: rtl/emi_pkg.sv
package emi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_RESP   = 2'd2,
    ST_GAP    = 2'd3
  } emi_state_e;

  localparam logic [3:0] REGION_TAG = 4'h1;
  localparam int SLOT_W = 4;
  localparam int WIN_W  = 24;
  localparam int DIV_W  = 3;
  localparam int DIV_LO = 2;
  localparam int DIV_HI = 6;
endpackage

// File: rtl/emi_clk_div.sv
module emi_clk_div #(
  parameter int DIV_W  = 3,
  parameter int DIV_LO = 2,
  parameter int DIV_HI = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] eff;
  logic [DIV_W-1:0] cnt;

  always_comb begin
    if (div_sel < DIV_W'(DIV_LO))      eff = DIV_W'(DIV_LO);
    else if (div_sel > DIV_W'(DIV_HI)) eff = DIV_W'(DIV_HI);
    else                               eff = div_sel;
  end

  assign tick = (cnt >= (eff - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  // R4: the phase counter never runs past the largest legal period
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < DIV_W'(DIV_HI));
  // R4: with a period of at least two cycles, ticks never land back to back
  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/emi_cs_decode.sv
module emi_cs_decode #(
  parameter int NUM_CS = 4,
  parameter int IDX_W  = 2
) (
  input  logic [31:0]                        addr,
  input  logic [NUM_CS-1:0]                  enable,
  input  logic [NUM_CS*emi_pkg::SLOT_W-1:0]  slot,
  output logic                               hit,
  output logic [IDX_W-1:0]                   idx,
  output logic [NUM_CS-1:0]                  sel
);
  localparam int SW = emi_pkg::SLOT_W;

  logic              in_region;
  logic [NUM_CS-1:0] match;

  assign in_region = (addr[31:28] == emi_pkg::REGION_TAG);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_win
    assign match[g] = in_region && enable[g] && (addr[27:24] == slot[g*SW +: SW]);
  end

  // lowest index wins: scan downward so the last match written is the lowest
  always_comb begin
    hit = 1'b0;
    idx = '0;
    sel = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
        sel = NUM_CS'(1) << i;
      end
    end
  end
endmodule

// File: rtl/emi_wait_sync.sv
module emi_wait_sync #(
  parameter int NUM_WAIT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_WAIT-1:0] pin_n,
  output logic [NUM_WAIT-1:0] sync_n
);
  for (genvar g = 0; g < NUM_WAIT; g++) begin : g_pin
    logic stage1;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1    <= 1'b1;
        sync_n[g] <= 1'b1;
      end else begin
        stage1    <= pin_n[g];
        sync_n[g] <= stage1;
      end
    end
  end
endmodule

// File: rtl/emi_wait_ctrl.sv
module emi_wait_ctrl #(
  parameter int NUM_CS   = 4,
  parameter int NUM_WAIT = 4,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 4,
  localparam int PIN_W   = (NUM_WAIT > 1) ? $clog2(NUM_WAIT) : 1,
  localparam int IDX_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int SW      = emi_pkg::SLOT_W,
  localparam int WIN_W   = emi_pkg::WIN_W,
  localparam int DIV_W   = emi_pkg::DIV_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DIV_W-1:0]        clk_div_sel,
  input  logic [NUM_CS-1:0]       cs_enable,
  input  logic [NUM_CS*SW-1:0]    cs_slot,
  input  logic [NUM_CS*CNT_W-1:0] cs_data_wait,
  input  logic [NUM_CS*CNT_W-1:0] cs_wrec_wait,
  input  logic [NUM_CS*CNT_W-1:0] cs_idle_wait,
  input  logic [NUM_CS-1:0]       cs_pin_use,
  input  logic [NUM_CS*PIN_W-1:0] cs_pin_sel,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [31:0]             req_addr,
  input  logic                    req_write,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic                    rsp_err,
  output logic [NUM_CS-1:0]       mem_cs_n,
  output logic                    mem_rd_n,
  output logic                    mem_wr_n,
  output logic [WIN_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  output logic                    mem_wdata_oe,
  input  logic [DATA_W-1:0]       mem_rdata,
  input  logic [NUM_WAIT-1:0]     ext_wait_n
);
  import emi_pkg::*;

  localparam int GAP_W = CNT_W + 1;

  emi_state_e        state;
  logic              tick;
  logic              restart;
  logic              dec_hit;
  logic [IDX_W-1:0]  dec_idx;
  logic [NUM_CS-1:0] dec_sel;
  logic [NUM_WAIT-1:0] wait_sync_n;

  logic [NUM_CS-1:0] sel_q;
  logic [WIN_W-1:0]  addr_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;
  logic [CNT_W-1:0]  dwait_q;
  logic [CNT_W-1:0]  ph_cnt;
  logic [GAP_W-1:0]  gap_q;
  logic [GAP_W-1:0]  gap_cnt;
  logic              use_q;
  logic [PIN_W-1:0]  pin_q;

  logic [CNT_W-1:0]  sel_dwait;
  logic [CNT_W-1:0]  sel_idle;
  logic [CNT_W-1:0]  sel_wrec;
  logic [GAP_W-1:0]  sel_gap;
  logic              accept;
  logic              wait_hold;
  logic              dwait_done;

  emi_clk_div #(
    .DIV_W (DIV_W),
    .DIV_LO(DIV_LO),
    .DIV_HI(DIV_HI)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_sel(clk_div_sel),
    .restart(restart),
    .tick   (tick)
  );

  emi_cs_decode #(
    .NUM_CS(NUM_CS),
    .IDX_W (IDX_W)
  ) u_dec (
    .addr  (req_addr),
    .enable(cs_enable),
    .slot  (cs_slot),
    .hit   (dec_hit),
    .idx   (dec_idx),
    .sel   (dec_sel)
  );

  emi_wait_sync #(
    .NUM_WAIT(NUM_WAIT)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (ext_wait_n),
    .sync_n(wait_sync_n)
  );

  // per-chip-select settings of the winning window
  assign sel_dwait = cs_data_wait[dec_idx*CNT_W +: CNT_W];
  assign sel_idle  = cs_idle_wait[dec_idx*CNT_W +: CNT_W];
  assign sel_wrec  = cs_wrec_wait[dec_idx*CNT_W +: CNT_W];
  assign sel_gap   = GAP_W'(sel_idle) + (req_write ? GAP_W'(sel_wrec) : GAP_W'(0));

  assign accept     = (state == ST_IDLE) && req_valid;
  assign wait_hold  = use_q && !wait_sync_n[pin_q];
  assign dwait_done = (ph_cnt >= dwait_q);
  assign restart    = (accept && dec_hit) ||
                      ((state == ST_RESP) && rsp_ready && (gap_q != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sel_q   <= '0;
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      dwait_q <= '0;
      ph_cnt  <= '0;
      gap_q   <= '0;
      gap_cnt <= '0;
      use_q   <= 1'b0;
      pin_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            addr_q  <= req_addr[WIN_W-1:0];
            write_q <= req_write;
            wdata_q <= req_wdata;
            ph_cnt  <= '0;
            if (dec_hit) begin
              state   <= ST_STROBE;
              sel_q   <= dec_sel;
              err_q   <= 1'b0;
              dwait_q <= sel_dwait;
              gap_q   <= sel_gap;
              use_q   <= cs_pin_use[dec_idx];
              pin_q   <= cs_pin_sel[dec_idx*PIN_W +: PIN_W];
            end else begin
              state <= ST_RESP;
              sel_q <= '0;
              err_q <= 1'b1;
              gap_q <= '0;
            end
          end
        end
        ST_STROBE: begin
          if (tick) begin
            if (!dwait_done) begin
              ph_cnt <= ph_cnt + 1'b1;
            end else if (!wait_hold) begin
              state <= ST_RESP;
              if (!write_q) rdata_q <= mem_rdata;
            end
          end
        end
        ST_RESP: begin
          if (rsp_ready) begin
            gap_cnt <= '0;
            state   <= (gap_q == '0) ? ST_IDLE : ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_cnt == gap_q - 1'b1) state <= ST_IDLE;
            else                         gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign rsp_valid    = (state == ST_RESP);
  assign rsp_rdata    = rdata_q;
  assign rsp_err      = err_q;
  assign mem_cs_n     = ~((state == ST_STROBE) ? sel_q : '0);
  assign mem_rd_n     = !((state == ST_STROBE) && !write_q);
  assign mem_wr_n     = !((state == ST_STROBE) && write_q);
  assign mem_wdata_oe = (state == ST_STROBE) && write_q;
  assign mem_addr     = addr_q;
  assign mem_wdata    = wdata_q;

  // R1: at most one chip select is driven
  p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));
  // R5: read and write strobes never overlap
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));
  // R4: a strobe only ends on a period boundary from the divider
  p_rd_end_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_n) |-> $past(tick));
  p_wr_end_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n) |-> $past(tick));
  // R10: a stalled response holds its contents
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));
  // R3: an error response follows a cycle with no strobe
  p_err_no_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && rsp_err |-> $past(mem_rd_n && mem_wr_n && (&mem_cs_n)));
  // R9: port open only while the memory bus is quiet
  p_ready_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&mem_cs_n) && mem_rd_n && mem_wr_n);
  // R7: an asserted synchronized wait after the data-wait keeps the strobe low
  p_wait_stretch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STROBE) && tick && dwait_done && wait_hold |=> !mem_rd_n || !mem_wr_n);
endmodule

// File: tb/emi_wait_ctrl_tb_top.sv
module emi_wait_ctrl_tb_top;
  localparam int NCS = 4;
  localparam int NW  = 4;
  localparam int DW  = 32;
  localparam int CW  = 4;
  localparam int PW  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    clk_div_sel = 3'd2;
  logic [NCS-1:0]    cs_enable = '0;
  logic [NCS*4-1:0]  cs_slot = '0;
  logic [NCS*CW-1:0] cs_data_wait = '0;
  logic [NCS*CW-1:0] cs_wrec_wait = '0;
  logic [NCS*CW-1:0] cs_idle_wait = '0;
  logic [NCS-1:0]    cs_pin_use = '0;
  logic [NCS*PW-1:0] cs_pin_sel = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [31:0]   req_addr = '0;
  logic          req_write = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_err;
  logic [NCS-1:0] mem_cs_n;
  logic          mem_rd_n, mem_wr_n;
  logic [23:0]   mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_wdata_oe;
  logic [DW-1:0] mem_rdata = '0;
  logic [NW-1:0] ext_wait_n = '1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int m_len, m_gap;
  logic [NCS-1:0] m_cs;
  logic m_cs_ok, m_addr_ok, m_kind_ok, m_busy_ok, m_rsp_valid, m_err, m_hold_ok;
  logic [DW-1:0] m_rdata;

  emi_wait_ctrl #(.NUM_CS(NCS), .NUM_WAIT(NW), .DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_div_sel(clk_div_sel),
    .cs_enable(cs_enable), .cs_slot(cs_slot), .cs_data_wait(cs_data_wait),
    .cs_wrec_wait(cs_wrec_wait), .cs_idle_wait(cs_idle_wait),
    .cs_pin_use(cs_pin_use), .cs_pin_sel(cs_pin_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata),
    .ext_wait_n(ext_wait_n)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int effd(input int s);
    return (s < 2) ? 2 : ((s > 6) ? 6 : s);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic cfg_cs(input int i, input logic en, input logic [3:0] slot, input int dw,
                        input int wrec, input int idle, input logic use_pin, input int pin);
    cs_enable[i]              = en;
    cs_slot[i*4 +: 4]         = slot;
    cs_data_wait[i*CW +: CW]  = CW'(dw);
    cs_wrec_wait[i*CW +: CW]  = CW'(wrec);
    cs_idle_wait[i*CW +: CW]  = CW'(idle);
    cs_pin_use[i]             = use_pin;
    cs_pin_sel[i*PW +: PW]    = PW'(pin);
  endtask

  task automatic access(input logic [31:0] addr, input logic wr, input logic [DW-1:0] wd,
                        input logic [DW-1:0] rd, input int rel, input int hold);
    int guard = 0;
    while (!req_ready && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    mem_rdata = rd; req_addr = addr; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    if (hold > 0) rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    m_len = 0; m_cs = '1; m_cs_ok = 1; m_addr_ok = 1; m_kind_ok = 1; m_busy_ok = 1;
    while ((!mem_rd_n || !mem_wr_n) && m_len < 400) begin
      m_len++;
      if (m_len == 1) m_cs = mem_cs_n;
      else if (mem_cs_n !== m_cs) m_cs_ok = 0;
      if (mem_addr !== addr[23:0]) m_addr_ok = 0;
      if (wr) begin
        if (mem_wr_n || !mem_rd_n || !mem_wdata_oe || mem_wdata !== wd) m_kind_ok = 0;
      end else begin
        if (mem_rd_n || !mem_wr_n || mem_wdata_oe) m_kind_ok = 0;
      end
      if (req_ready) m_busy_ok = 0;
      if (m_len == rel) ext_wait_n = '1;
      @(negedge clk);
    end
    if (m_len == 0) m_cs = mem_cs_n;
    m_rsp_valid = rsp_valid; m_err = rsp_err; m_rdata = rsp_rdata; m_hold_ok = 1;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_err !== m_err || rsp_rdata !== m_rdata || req_ready ||
          !mem_rd_n || !mem_wr_n) m_hold_ok = 0;
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    m_gap = 0;
    while (!req_ready && m_gap < 1000) begin
      m_gap++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 cs_n at reset", mem_cs_n, 4'hF);
    chk("R11 rd_n at reset", mem_rd_n, 1);
    chk("R11 wr_n at reset", mem_wr_n, 1);
    chk("R11 req_ready at reset", req_ready, 1);
    chk("R11 rsp_valid at reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    cfg_cs(0, 1, 4'h3, 0, 0, 0, 0, 0);
    cfg_cs(1, 1, 4'h7, 0, 0, 0, 0, 1);
    cfg_cs(2, 1, 4'hA, 0, 0, 0, 0, 2);
    cfg_cs(3, 0, 4'hC, 0, 0, 0, 0, 3);

    // R4 R5 R6: sweep of period, data wait, idle, recovery and direction
    for (int dv = 2; dv <= 6; dv++) begin
      for (int dw = 0; dw <= 3; dw++) begin
        for (int wr = 0; wr <= 1; wr++) begin
          for (int id = 0; id <= 2; id++) begin
            for (int rc = 0; rc <= 2; rc++) begin
              clk_div_sel = 3'(dv);
              cfg_cs(0, 1, 4'h3, dw, rc, id, 0, 0);
              access(32'h13AB_CD00 + 32'(dw * 16 + id * 4 + rc), wr[0],
                     32'hA500_0000 + 32'(dv), 32'h5A00_0000 + 32'(dw), 0, 0);
              chk("R5 strobe length", m_len, (1 + dw) * dv);
              chk("R6 gap length", m_gap, (id + (wr ? rc : 0)) * dv);
              chk("R5 strobe kind and data", m_kind_ok, 1);
              if (dv == 2 && id == 0 && rc == 0) begin
                chk("R1 chip select cs0", {m_cs_ok, m_cs}, {1'b1, 4'hE});
                chk("R1 address bits", m_addr_ok, 1);
                chk("R9 ready low in strobe", m_busy_ok, 1);
                chk("R3 no error on hit", m_err, 0);
                if (!wr) chk("R10 read data", m_rdata, 32'h5A00_0000 + 32'(dw));
              end
            end
          end
        end
      end
    end

    // R4: out-of-range divider settings clamp
    cfg_cs(0, 1, 4'h3, 1, 0, 0, 0, 0);
    clk_div_sel = 3'd0;
    access(32'h1300_0040, 0, 0, 32'h1, 0, 0);
    chk("R4 div 0 clamps to 2", m_len, 4);
    clk_div_sel = 3'd1;
    access(32'h1300_0040, 0, 0, 32'h1, 0, 0);
    chk("R4 div 1 clamps to 2", m_len, 4);
    clk_div_sel = 3'd7;
    access(32'h1300_0040, 0, 0, 32'h1, 0, 0);
    chk("R4 div 7 clamps to 6", m_len, 12);

    // R1: other windows
    clk_div_sel = 3'd2;
    access(32'h17FF_FFFC, 0, 0, 32'h77, 0, 0);
    chk("R1 chip select cs1", {m_cs_ok, m_cs}, {1'b1, 4'hD});
    access(32'h1A00_1234, 1, 32'hBEEF, 0, 0, 0);
    chk("R1 chip select cs2", {m_cs_ok, m_cs}, {1'b1, 4'hB});
    chk("R1 address bits cs2", m_addr_ok, 1);

    // R2: overlapping slot, lowest index wins along with its timing
    cfg_cs(1, 1, 4'h5, 2, 0, 0, 0, 0);
    cfg_cs(2, 1, 4'h5, 0, 0, 0, 0, 0);
    access(32'h1500_0000, 0, 0, 32'h22, 0, 0);
    chk("R2 lower index wins", m_cs, 4'hD);
    chk("R2 winner timing", m_len, 6);
    cfg_cs(1, 0, 4'h5, 2, 0, 0, 0, 0);
    access(32'h1500_0000, 0, 0, 32'h22, 0, 0);
    chk("R2 next index when lower disabled", m_cs, 4'hB);
    chk("R2 next index timing", m_len, 2);

    // R3: misses
    cfg_cs(0, 1, 4'h3, 0, 2, 2, 0, 0);
    access(32'h2300_0000, 0, 0, 0, 0, 0);
    chk("R3 outside region err", {m_err, m_rsp_valid}, 2'b11);
    chk("R3 outside region no strobe", m_len, 0);
    chk("R3 outside region no cs", m_cs, 4'hF);
    chk("R3 no gap after error", m_gap, 0);
    access(32'h1E00_0000, 1, 32'h1, 0, 0, 0);
    chk("R3 unmapped slot err", m_err, 1);
    chk("R3 unmapped slot no strobe", m_len, 0);
    access(32'h1C00_0000, 0, 0, 0, 0, 0);
    chk("R3 disabled window err", m_err, 1);
    chk("R3 disabled window no strobe", m_len, 0);

    // R7: external wait release in each strobe cycle
    cfg_cs(0, 1, 4'h3, 1, 0, 0, 1, 1);
    for (int dv = 2; dv <= 4; dv++) begin
      for (int n = 1; n <= 14; n++) begin
        clk_div_sel = 3'(dv);
        ext_wait_n = 4'b1101;
        repeat (3) @(negedge clk);
        access(32'h1300_0000, 0, 0, 32'hC0DE, n, 0);
        ext_wait_n = '1;
        chk("R7 stretched strobe", m_len, dv * imax(2, (n + 2 + dv - 1) / dv));
        chk("R7 read data after wait", m_rdata, 32'hC0DE);
      end
    end

    // R8: wait ignored when disabled or on another pin
    clk_div_sel = 3'd3;
    cfg_cs(0, 1, 4'h3, 1, 0, 0, 0, 1);
    ext_wait_n = 4'b1101;
    repeat (3) @(negedge clk);
    access(32'h1300_0000, 0, 0, 0, 0, 0);
    chk("R8 wait unused", m_len, 6);
    cfg_cs(0, 1, 4'h3, 1, 0, 0, 1, 2);
    access(32'h1300_0000, 1, 32'h9, 0, 0, 0);
    chk("R8 other pin ignored", m_len, 6);
    ext_wait_n = '1;

    // R10: response back-pressure
    cfg_cs(0, 1, 4'h3, 0, 0, 1, 0, 0);
    clk_div_sel = 3'd2;
    access(32'h1300_0010, 0, 0, 32'hFACE_0001, 0, 5);
    chk("R10 held response", m_hold_ok, 1);
    chk("R10 held read data", m_rdata, 32'hFACE_0001);
    chk("R6 gap after held response", m_gap, 2);
    access(32'h4000_0000, 0, 0, 0, 0, 3);
    chk("R10 held error response", {m_hold_ok, m_err}, 2'b11);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule